// File: doc/BRIEF.md
# Indirect-Context DMA Channel Engine

This block is one DMA channel. Each peripheral request moves a single byte between a peripheral data register and a target. The target is either an on-chip register file (8-bit addressing) or memory (16-bit addressing). The channel holds no persistent address or count state of its own. Both values live in the register file, at locations given by pointer registers in the peripheral's register page. For every accepted request the engine runs a fixed sequence:

1. It reads the count and address from the register file.
2. It moves the data item.
3. It writes back the incremented address.
4. It writes back the decremented count.

It raises a one-cycle end-of-block interrupt when the count reaches zero.

The register file and memory are external and have a one-cycle synchronous read latency, as block RAM does. Bit 0 of the count pointer selects the mode:

- In register-file mode, the address byte sits at the even location of the pair and the count byte at the odd location.
- In memory mode, the count and the address are each a 16-bit pair. The high byte is at the even location and the low byte at the odd location. A second pointer locates the address pair.

Top module: `dma_chan_engine`

## Requirements
- R1: With `cnt_ptr[0]`=1 (register-file mode), the engine uses the pair base P = `cnt_ptr` with bit 0 cleared. The address byte is at P and the count byte at P+1. The data target is `rf` at the 8-bit address, and `mem_we` stays low.
- R2: With `dir`=0 (peripheral to target), `per_rdata` is written to the target location selected by the address that was read.
- R3: With `dir`=1 (target to peripheral), the byte at the target location appears on `per_wdata` with a one-cycle `per_we` pulse before `ack`.
- R4: The address is written back incremented by one. In register-file mode the increment wraps within 8 bits.
- R5: The count is written back decremented by one.
- R6: With `cnt_ptr[0]`=0 (memory mode), the count pair is at `cnt_ptr` with bit 0 cleared and the address pair is at `adr_ptr` with bit 0 cleared. Each pair holds its high byte at the even location and its low byte at the odd location. The data goes to `mem` at the 16-bit address.
- R7: `eob_irq` pulses for one cycle, together with `ack`, exactly when the decremented count is zero.
- R8: A request that finds a zero count is ignored: there is no `ack`, no data move and no write-back. After a nonzero count is stored, requests are served again.
- R9: Each served request gets exactly one single-cycle `ack`. `ack` comes 8 cycles after the request is sampled in register-file mode and 12 in memory mode, plus one when `dir`=1. All write-backs are complete by then.
- R10: In reset, `ack`, `eob_irq`, `per_we`, `rf_we` and `mem_we` are low.
- R11: In memory mode, the address increment carries from the low byte into the high byte, and the count decrement borrows from the high byte into the low byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Peripheral transfer request, held until `ack` |
| dir | input | 1 | 0: peripheral to target, 1: target to peripheral; sampled with `req` |
| per_rdata | input | 8 | Peripheral data register contents |
| per_wdata | output | 8 | Byte for the peripheral data register |
| per_we | output | 1 | Write strobe for the peripheral data register |
| ack | output | 1 | One-cycle acknowledge of a served request |
| cnt_ptr | input | 8 | Count pointer; bit 0 selects register-file mode |
| adr_ptr | input | 8 | Address-pair pointer used in memory mode |
| rf_addr | output | 8 | Register-file address |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | 8 | Register-file write data |
| rf_rdata | input | 8 | Register-file read data, one cycle after `rf_addr` |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after `mem_addr` |
| eob_irq | output | 1 | One-cycle end-of-block interrupt |

## Verification
The engine samples a request on a rising edge. In register-file mode, `ack` is visible 8 edges later; in memory mode, 12 edges later; a target-to-peripheral transfer adds one edge in either mode. `eob_irq` lands on the same edge as `ack`, and `per_we` one or more edges before it. The bench raises `req` on a falling edge and counts the following falling edges until `ack` is seen. It compares that count with the expected latency. `per_we` and `eob_irq` are recorded on the same falling-edge samples, and the register-file and memory contents are checked once the `ack` cycle has passed. For an ignored request, the bench holds `req` for 40 cycles and confirms that no `ack` occurs and that no location changes.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_CHK,
    ST_XF,
    ST_XR,
    ST_WB
  } dma_st_e;

  localparam int unsigned REG_STEPS = 2;
  localparam int unsigned MEM_STEPS = 4;
endpackage

// File: rtl/dma_ctx.sv
module dma_ctx #(
  parameter int unsigned BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            cap_en,
  input  logic [1:0]      cap_slot,
  input  logic            rf_mode,
  input  logic [BW-1:0]   cap_byte,
  output logic [2*BW-1:0] cnt_q,
  output logic [2*BW-1:0] adr_q,
  output logic [2*BW-1:0] cnt_nxt,
  output logic [2*BW-1:0] adr_nxt
);
  localparam int unsigned WW = 2 * BW;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      adr_q <= '0;
    end else if (cap_en) begin
      if (rf_mode) begin
        if (cap_slot == 2'd0) cnt_q[BW-1:0] <= cap_byte;
        else                  adr_q[BW-1:0] <= cap_byte;
      end else begin
        case (cap_slot)
          2'd0:    cnt_q[WW-1:BW] <= cap_byte;
          2'd1:    cnt_q[BW-1:0]  <= cap_byte;
          2'd2:    adr_q[WW-1:BW] <= cap_byte;
          default: adr_q[BW-1:0]  <= cap_byte;
        endcase
      end
    end
  end

  always_comb begin
    cnt_nxt = cnt_q - 1'b1;
    if (rf_mode) adr_nxt = {{BW{1'b0}}, adr_q[BW-1:0] + 1'b1};
    else         adr_nxt = adr_q + 1'b1;
  end
endmodule

// File: rtl/dma_step_map.sv
module dma_step_map #(
  parameter int unsigned BW = 8,
  parameter int unsigned PW = 8
) (
  input  logic            rf_mode,
  input  logic            is_wb,
  input  logic [2:0]      step,
  input  logic [PW-1:0]   cnt_ptr,
  input  logic [PW-1:0]   adr_ptr,
  input  logic [2*BW-1:0] cnt_nxt,
  input  logic [2*BW-1:0] adr_nxt,
  output logic [PW-1:0]   map_addr,
  output logic [BW-1:0]   map_data
);
  localparam int unsigned WW = 2 * BW;

  logic [PW-1:0] cbase, abase;
  assign cbase = {cnt_ptr[PW-1:1], 1'b0};
  assign abase = {adr_ptr[PW-1:1], 1'b0};

  always_comb begin
    map_addr = cbase;
    map_data = '0;
    if (rf_mode) begin
      if (is_wb) begin
        if (step == 3'd0) begin map_addr = cbase;       map_data = adr_nxt[BW-1:0]; end
        else              begin map_addr = cbase | 1'b1; map_data = cnt_nxt[BW-1:0]; end
      end else begin
        if (step == 3'd0) map_addr = cbase | 1'b1;
        else              map_addr = cbase;
      end
    end else begin
      if (is_wb) begin
        case (step)
          3'd0:    begin map_addr = abase;        map_data = adr_nxt[WW-1:BW]; end
          3'd1:    begin map_addr = abase | 1'b1; map_data = adr_nxt[BW-1:0];  end
          3'd2:    begin map_addr = cbase;        map_data = cnt_nxt[WW-1:BW]; end
          default: begin map_addr = cbase | 1'b1; map_data = cnt_nxt[BW-1:0];  end
        endcase
      end else begin
        case (step)
          3'd0:    map_addr = cbase;
          3'd1:    map_addr = cbase | 1'b1;
          3'd2:    map_addr = abase;
          default: map_addr = abase | 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int unsigned BW = 8,
  parameter int unsigned PW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req,
  input  logic            dir,
  input  logic [BW-1:0]   per_rdata,
  output logic [BW-1:0]   per_wdata,
  output logic            per_we,
  output logic            ack,
  input  logic [PW-1:0]   cnt_ptr,
  input  logic [PW-1:0]   adr_ptr,
  output logic [PW-1:0]   rf_addr,
  output logic            rf_we,
  output logic [BW-1:0]   rf_wdata,
  input  logic [BW-1:0]   rf_rdata,
  output logic [2*BW-1:0] mem_addr,
  output logic            mem_we,
  output logic [BW-1:0]   mem_wdata,
  input  logic [BW-1:0]   mem_rdata,
  output logic            eob_irq
);
  import dma_pkg::*;
  localparam int unsigned WW = 2 * BW;

  dma_st_e       st;
  logic [2:0]    step, n_steps;
  logic          mode_q, dir_q;
  logic [PW-1:0] cptr_q, aptr_q;
  logic [WW-1:0] cnt_q, adr_q, cnt_nxt, adr_nxt;
  logic [PW-1:0] map_addr;
  logic [BW-1:0] map_data;
  logic          cap_en, clr;

  assign n_steps = mode_q ? 3'(REG_STEPS) : 3'(MEM_STEPS);
  assign clr     = (st == ST_IDLE) && req;
  assign cap_en  = (st == ST_RD) && (step != 3'd0);

  dma_ctx #(.BW(BW)) u_ctx (
    .clk(clk), .rst(rst), .clr(clr), .cap_en(cap_en),
    .cap_slot(2'(step - 3'd1)), .rf_mode(mode_q), .cap_byte(rf_rdata),
    .cnt_q(cnt_q), .adr_q(adr_q), .cnt_nxt(cnt_nxt), .adr_nxt(adr_nxt)
  );

  dma_step_map #(.BW(BW), .PW(PW)) u_map (
    .rf_mode(mode_q), .is_wb(st == ST_WB), .step(step),
    .cnt_ptr(cptr_q), .adr_ptr(aptr_q), .cnt_nxt(cnt_nxt), .adr_nxt(adr_nxt),
    .map_addr(map_addr), .map_data(map_data)
  );

  always_comb begin
    rf_addr   = map_addr;
    rf_wdata  = map_data;
    rf_we     = (st == ST_WB);
    mem_addr  = adr_q;
    mem_wdata = per_rdata;
    mem_we    = 1'b0;
    if (st == ST_XF) begin
      if (mode_q) begin
        rf_addr  = adr_q[PW-1:0];
        rf_wdata = per_rdata;
        rf_we    = !dir_q;
      end else begin
        mem_we = !dir_q;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      step      <= '0;
      mode_q    <= 1'b0;
      dir_q     <= 1'b0;
      cptr_q    <= '0;
      aptr_q    <= '0;
      ack       <= 1'b0;
      eob_irq   <= 1'b0;
      per_we    <= 1'b0;
      per_wdata <= '0;
    end else begin
      ack     <= 1'b0;
      eob_irq <= 1'b0;
      per_we  <= 1'b0;
      case (st)
        ST_IDLE: if (req) begin
          mode_q <= cnt_ptr[0];
          dir_q  <= dir;
          cptr_q <= cnt_ptr;
          aptr_q <= adr_ptr;
          step   <= '0;
          st     <= ST_RD;
        end
        ST_RD: begin
          step <= step + 3'd1;
          if (step == n_steps) st <= ST_CHK;
        end
        ST_CHK: st <= (cnt_q == '0) ? ST_IDLE : ST_XF;
        ST_XF: begin
          step <= '0;
          st   <= dir_q ? ST_XR : ST_WB;
        end
        ST_XR: begin
          per_we    <= 1'b1;
          per_wdata <= mode_q ? rf_rdata : mem_rdata;
          st        <= ST_WB;
        end
        ST_WB: begin
          step <= step + 3'd1;
          if (step == n_steps - 3'd1) begin
            st      <= ST_IDLE;
            ack     <= 1'b1;
            eob_irq <= (cnt_nxt == '0);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: the acknowledge is a single-cycle pulse
  p_ack_single_r9: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);
  // R9: the last register-file write-back precedes the acknowledge
  p_wb_before_ack_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> $past(rf_we));
  // R7: end of block only comes with an acknowledge
  p_eob_on_ack_r7: assert property (@(posedge clk) disable iff (rst)
    eob_irq |-> ack);
  // R7: end of block only when the count read was one
  p_eob_last_r7: assert property (@(posedge clk) disable iff (rst)
    eob_irq |-> (cnt_q == WW'(1)));
  // R8: no acknowledge for a zero count
  p_ack_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    ack |-> (cnt_q != '0));
  // R3: peripheral write only for target-to-peripheral transfers
  p_perwe_dir_r3: assert property (@(posedge clk) disable iff (rst)
    per_we |-> dir_q);
  // R1: register-file mode never writes memory
  p_no_mem_rfmode_r1: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE && mode_q) |-> !mem_we);
endmodule

// File: tb/dma_chan_engine_test.sv
module dma_chan_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        dir = 1'b0;
  logic [7:0]  per_rdata = '0;
  logic [7:0]  per_wdata;
  logic        per_we, ack, eob_irq;
  logic [7:0]  cnt_ptr = '0, adr_ptr = '0;
  logic [7:0]  rf_addr, rf_wdata, rf_rdata;
  logic        rf_we, mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata;

  logic [7:0] rf  [256];
  logic [7:0] mem [4096];

  int errors = 0;
  int checks = 0;
  int lat, acks, eobs, pwe_cnt;
  logic [7:0] pdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_engine uut (
    .clk(clk), .rst(rst), .req(req), .dir(dir), .per_rdata(per_rdata),
    .per_wdata(per_wdata), .per_we(per_we), .ack(ack),
    .cnt_ptr(cnt_ptr), .adr_ptr(adr_ptr),
    .rf_addr(rf_addr), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .eob_irq(eob_irq)
  );

  always @(posedge clk) begin
    if (rf_we) rf[rf_addr] <= rf_wdata;
    rf_rdata <= rf[rf_addr];
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // raise a request and observe the handshake on falling edges
  task automatic do_req(input logic d, input int limit);
    lat = 0; acks = 0; eobs = 0; pwe_cnt = 0; pdata = '0;
    @(negedge clk);
    dir = d;
    req = 1'b1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (per_we) begin pwe_cnt++; pdata = per_wdata; end
      if (eob_irq) eobs++;
      if (ack) begin
        acks++;
        if (lat == 0) lat = i;
        req = 1'b0;
      end
    end
    req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (ack) acks++;
      if (eob_irq) eobs++;
    end
  endtask

  task automatic t_reset;
    chk("R10 ack in reset", ack, 0);
    chk("R10 eob in reset", eob_irq, 0);
    chk("R10 per_we in reset", per_we, 0);
    chk("R10 rf_we in reset", rf_we, 0);
    chk("R10 mem_we in reset", mem_we, 0);
  endtask

  task automatic t_reg_write;
    cnt_ptr = 8'h21; rf[8'h20] = 8'h40; rf[8'h21] = 8'h03;
    per_rdata = 8'hA5;
    do_req(1'b0, 20);
    chk("R2 rf data written", rf[8'h40], 8'hA5);
    chk("R1 R4 address incremented at even slot", rf[8'h20], 8'h41);
    chk("R1 R5 count decremented at odd slot", rf[8'h21], 8'h02);
    chk("R9 single ack", acks, 1);
    chk("R9 latency reg mode", lat, 8);
    chk("R7 no eob mid-block", eobs, 0);
  endtask

  task automatic t_reg_read;
    rf[8'h41] = 8'h5C;
    do_req(1'b1, 20);
    chk("R3 peripheral data", pdata, 8'h5C);
    chk("R3 single per_we", pwe_cnt, 1);
    chk("R9 latency reg read", lat, 9);
    chk("R4 address", rf[8'h20], 8'h42);
    chk("R5 count", rf[8'h21], 8'h01);
  endtask

  task automatic t_eob;
    per_rdata = 8'h77;
    do_req(1'b0, 20);
    chk("R7 eob pulse", eobs, 1);
    chk("R2 last data", rf[8'h42], 8'h77);
    chk("R5 count reaches zero", rf[8'h21], 8'h00);
  endtask

  task automatic t_ignore;
    rf[8'h43] = 8'h11;
    per_rdata = 8'hEE;
    do_req(1'b0, 40);
    chk("R8 no ack at zero count", acks, 0);
    chk("R8 no data move", rf[8'h43], 8'h11);
    chk("R8 address untouched", rf[8'h20], 8'h43);
    chk("R8 no eob", eobs, 0);
    rf[8'h21] = 8'h01;
    do_req(1'b0, 20);
    chk("R8 served after reload", acks, 1);
    chk("R8 data after reload", rf[8'h43], 8'hEE);
  endtask

  task automatic t_mem;
    cnt_ptr = 8'h30; adr_ptr = 8'h35;
    rf[8'h30] = 8'h00; rf[8'h31] = 8'h02;
    rf[8'h34] = 8'h01; rf[8'h35] = 8'h23;
    per_rdata = 8'h3C;
    do_req(1'b0, 30);
    chk("R6 mem data", mem[12'h123], 8'h3C);
    chk("R6 address hi", rf[8'h34], 8'h01);
    chk("R6 address lo", rf[8'h35], 8'h24);
    chk("R6 count hi", rf[8'h30], 8'h00);
    chk("R6 count lo", rf[8'h31], 8'h01);
    chk("R9 latency mem mode", lat, 12);
  endtask

  task automatic t_carry;
    rf[8'h34] = 8'h12; rf[8'h35] = 8'hFF;
    rf[8'h30] = 8'h01; rf[8'h31] = 8'h00;
    mem[12'h2FF] = 8'h9E;
    do_req(1'b1, 30);
    chk("R11 read data", pdata, 8'h9E);
    chk("R11 address carry hi", rf[8'h34], 8'h13);
    chk("R11 address carry lo", rf[8'h35], 8'h00);
    chk("R11 count borrow hi", rf[8'h30], 8'h00);
    chk("R11 count borrow lo", rf[8'h31], 8'hFF);
    chk("R9 latency mem read", lat, 13);
    chk("R7 no eob", eobs, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) rf[i] = 8'h00;
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset;
    rst = 1'b0;
    t_reg_write;
    t_reg_read;
    t_eob;
    t_ignore;
    t_mem;
    t_carry;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule